// File: doc/BRIEF.md
# Timing Error Detecting Pipeline Register

This block is a bank of pipeline register bits built for operation at a supply voltage pushed below the point where every path is guaranteed to meet timing. Each bit holds a main register that captures data at the normal clock edge and a shadow register that captures the same data line again at a later phase. Data that arrives late is caught by the shadow copy but missed by the main one. The block then compares the two copies.

When the copies differ, the stage copies the shadow value into the main register. For one cycle it raises an error flag with a per-bit mismatch mask and a stall request, so that upstream logic replays the operation instead of committing it. A saturating error counter goes out to an external supply-voltage controller, which uses it as its error rate measure.

The delayed clock is not built inside the block. Two capture strobes on one fast clock stand in for the two phases: one marks the normal capture edge and one marks the delayed capture edge. The delayed strobe comes after the normal one and before the next normal capture.

Top module: `tedff_stage`

## Requirements
- R1: After reset, `q`, `err`, `err_bits`, `stall` and `err_count` are all zero.
- R2: On a clock edge with `cap_main` high, `q` takes the value of `d` at that edge. With neither `cap_main` nor a correction at an edge, `q` keeps its value.
- R3: The shadow copy takes `d` on a clock edge with `cap_shadow` high. The edge that follows it is the compare edge, where every bit of the main copy is checked against the shadow copy.
- R4: At a compare edge with any mismatching bit, `q` takes the shadow value. The new value is visible from that edge on.
- R5: After a compare edge with a mismatch, `err` is high for exactly one cycle. In that same cycle `err_bits` equals main XOR shadow, with bit i set for a mismatch in bit i. In every other cycle `err` is low and `err_bits` is zero.
- R6: `stall` is high in exactly the cycles in which `err` is high, one cycle per detected error.
- R7: `err_count` increases by one at each compare edge with a mismatch. It stops at 2^CNT_W-1 and does not wrap.
- R8: A compare edge with no mismatch leaves `q` and `err_count` unchanged and raises neither `err` nor `stall`.
- R9: At a compare edge with a mismatch, the correction wins over a `cap_main` strobe at the same edge, so `q` takes the shadow value and not `d`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_main | input | 1 | Normal capture strobe |
| cap_shadow | input | 1 | Delayed capture strobe |
| d | input | WIDTH | Data from the upstream logic path |
| q | output | WIDTH | Registered stage output, corrected after errors |
| err | output | 1 | One-cycle error flag |
| err_bits | output | WIDTH | Per-bit mismatch mask, valid while `err` is high |
| stall | output | 1 | One-cycle replay request to upstream |
| err_count | output | CNT_W | Saturating error count for the voltage controller |

## Verification
The assertions assume that the two strobes are never high together and that each delayed strobe follows its own normal strobe, with at least one quiet edge before the next delayed strobe. Under those conditions every error pulse is isolated. The bench drives each operation as a fixed four-edge frame: normal capture, delayed capture, compare, then a quiet edge. A random late-arrival mask picks which bits change between the two captures, so the strobe ordering holds throughout. One directed frame raises `cap_main` on the compare edge to exercise the precedence rule.

// File: rtl/tedff_pkg.sv
package tedff_pkg;

  // Saturating increment: returns v+1 unless v already equals lim.
  function automatic logic [31:0] sat_add1(input logic [31:0] v, input logic [31:0] lim);
    if (v >= lim) return lim;
    return v + 32'd1;
  endfunction

  // Per-bit mismatch between two register copies.
  function automatic logic [31:0] diff_mask(input logic [31:0] a, input logic [31:0] b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/tedff_cell.sv
module tedff_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic cap_main,
  input  logic cap_shadow,
  input  logic fix,
  output logic q,
  output logic shadow
);
  logic main_q;
  logic shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= 1'b0;
    end else if (fix) begin
      main_q <= shadow_q;
    end else if (cap_main) begin
      main_q <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
    end else if (cap_shadow) begin
      shadow_q <= d;
    end
  end

  assign q      = main_q;
  assign shadow = shadow_q;

  // R4, R9: correction loads the shadow copy
  a_r4_corrected: assert property (@(posedge clk) disable iff (!rst_n)
    fix |=> (main_q == $past(shadow_q)));

  // R2: without capture or correction the main copy holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_main && !fix) |=> (main_q == $past(main_q)));

endmodule

// File: rtl/tedff_err_ctrl.sv
module tedff_err_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_main,
  input  logic             cap_shadow,
  input  logic [WIDTH-1:0] main_vec,
  input  logic [WIDTH-1:0] shadow_vec,
  output logic             fix,
  output logic             err,
  output logic [WIDTH-1:0] err_bits,
  output logic             stall
);
  import tedff_pkg::*;

  logic             cmp_pending;
  logic [WIDTH-1:0] raw_diff;
  logic             err_q;
  logic             stall_q;
  logic [WIDTH-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_pending <= 1'b0;
    else        cmp_pending <= cap_shadow;
  end

  assign raw_diff = cmp_pending
                  ? WIDTH'(diff_mask(32'(main_vec), 32'(shadow_vec)))
                  : '0;
  assign fix      = |raw_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      stall_q <= 1'b0;
      bits_q  <= '0;
    end else begin
      err_q   <= fix;
      stall_q <= fix;
      bits_q  <= raw_diff;
    end
  end

  assign err      = err_q;
  assign stall    = stall_q;
  assign err_bits = bits_q;

  // R3: input rule, the two strobes never coincide
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_main && cap_shadow));

  // R5: an error pulse carries a nonzero mask and lasts one cycle
  a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_bits != '0));
  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (err_bits == '0));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !fix) |=> !err);

  // R6: stall accompanies the error flag
  a_r6_stall_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> err);

endmodule

// File: rtl/tedff_err_counter.sv
module tedff_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  import tedff_pkg::*;

  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (hit) cnt_q <= CNT_W'(sat_add1(32'(cnt_q), 32'(MAXV)));
  end

  assign count = cnt_q;

  // R7: the count moves only by one step
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R7: no wrap at the top
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == MAXV) |-> (cnt_q == MAXV));

endmodule

// File: rtl/tedff_stage.sv
module tedff_stage #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_main,
  input  logic             cap_shadow,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             err,
  output logic [WIDTH-1:0] err_bits,
  output logic             stall,
  output logic [CNT_W-1:0] err_count
);
  logic [WIDTH-1:0] main_vec;
  logic [WIDTH-1:0] shadow_vec;
  logic             fix;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    tedff_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .d          (d[i]),
      .cap_main   (cap_main),
      .cap_shadow (cap_shadow),
      .fix        (fix),
      .q          (main_vec[i]),
      .shadow     (shadow_vec[i])
    );
  end

  tedff_err_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_main   (cap_main),
    .cap_shadow (cap_shadow),
    .main_vec   (main_vec),
    .shadow_vec (shadow_vec),
    .fix        (fix),
    .err        (err),
    .err_bits   (err_bits),
    .stall      (stall)
  );

  tedff_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (fix),
    .count (err_count)
  );

  assign q = main_vec;

  // R8: the count never moves without an error pulse following
  a_r8_count_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> err);

endmodule

// File: tb/tedff_stage_bench.sv
module tedff_stage_bench;
  localparam int W  = 16;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_main = 1'b0;
  logic          cap_shadow = 1'b0;
  logic [W-1:0]  d = '0;
  logic [W-1:0]  q;
  logic          err;
  logic [W-1:0]  err_bits;
  logic          stall;
  logic [CW-1:0] err_count;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_cnt = '0;
  logic [W-1:0]  exp_q = '0;

  always #4 clk = ~clk;

  tedff_stage #(.WIDTH(W), .CNT_W(CW)) u_tedff_stage (
    .clk(clk), .rst_n(rst_n), .cap_main(cap_main), .cap_shadow(cap_shadow),
    .d(d), .q(q), .err(err), .err_bits(err_bits), .stall(stall),
    .err_count(err_count)
  );

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c, input logic hit);
    if (!hit) return c;
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One frame: normal capture, delayed capture, compare, quiet edge.
  task automatic frame(input logic [W-1:0] early, input logic [W-1:0] settled,
                       input logic ovr, input logic [W-1:0] junk);
    logic hit;
    hit = (early != settled);
    @(negedge clk);
    cap_main = 1'b1; d = early;
    @(negedge clk);
    chk("R2 main capture", 32'(q), 32'(early));
    cap_main = 1'b0; cap_shadow = 1'b1; d = settled;
    @(negedge clk);
    cap_shadow = 1'b0;
    if (ovr) begin cap_main = 1'b1; d = junk; end
    @(negedge clk);
    cap_main = 1'b0;
    exp_q   = (ovr && !hit) ? junk : settled;
    exp_cnt = next_cnt(exp_cnt, hit);
    if (ovr) chk("R9 correction precedence", 32'(q), 32'(exp_q));
    else if (hit) chk("R4 corrected output", 32'(q), 32'(exp_q));
    else chk("R8 output unchanged", 32'(q), 32'(exp_q));
    chk("R5 error flag", 32'(err), 32'(hit));
    chk("R5 mismatch mask", 32'(err_bits), 32'(early ^ settled));
    chk("R6 stall", 32'(stall), 32'(hit));
    chk("R7 error count", 32'(err_count), 32'(exp_cnt));
    @(negedge clk);
    chk("R5 flag clears", 32'(err), 32'd0);
    chk("R6 stall clears", 32'(stall), 32'd0);
    chk("R5 mask clears", 32'(err_bits), 32'd0);
    chk("R2 hold", 32'(q), 32'(exp_q));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset q", 32'(q), 32'd0);
    chk("R1 reset err", 32'(err), 32'd0);
    chk("R1 reset stall", 32'(stall), 32'd0);
    chk("R1 reset mask", 32'(err_bits), 32'd0);
    chk("R1 reset count", 32'(err_count), 32'd0);
    rst_n = 1'b1;

    // directed corners
    frame(16'h1234, 16'h1234, 1'b0, '0);     // R8 no late data
    frame(16'h0000, 16'h0001, 1'b0, '0);     // R3 single late bit
    frame(16'hFFFF, 16'h0000, 1'b0, '0);     // R4 all bits late
    frame(16'hA5A5, 16'h5A5A, 1'b1, 16'h7777); // R9 capture on compare edge
    frame(16'h8000, 16'h8000, 1'b0, '0);

    // random frames, enough to saturate the 4-bit count (R7)
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] e;
      logic [W-1:0] late;
      e    = W'($urandom);
      late = ($urandom % 3 == 0) ? '0 : W'($urandom);
      frame(e, e ^ late, 1'b0, '0);
    end
    chk("R7 saturated count", 32'(err_count), 32'(CMAX));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule